// File: doc/BRIEF.md
# Triggered Waveform Playback Sequencer

This block turns a list of stored transitions into a timed, multi-line digital waveform. Each stored entry pairs an output vector with a hold count and a stop flag. When an external trigger rises, the block begins at entry zero. It applies each entry's output vector for the programmed number of clock cycles and then moves on to the following entry with no gap. After the flagged entry has run out, playback stops and the outputs fall back to their idle value. The time resolution is one clock period, so a clock of 100 MHz or faster gives 10 ns steps or finer.

A host rewrites the waveform through a separate write port without touching the logic. The storage is held in two banks, and a per-entry record tracks which bank holds the newest copy of each entry. As a result, a write that arrives while a run is in progress never disturbs that run. The write is stored for the next trigger. The trigger input is asynchronous and passes through a synchronizer before its rising edge is detected.

Top module: `wave_seq_top`

## Requirements
- R1: After reset, `wave_out` equals the idle value (all zeros by default) and `busy` is low.
- R2: The trigger is synchronized through two flops and acts on its rising edge. If `trig_in` rises before clock edge E1 while the block is idle, `busy` goes high at edge E3, and the first entry's outputs appear at edge E4.
- R3: An entry is written as `wr_data`, with the delay count in bits [DLY_W-1:0], the output vector in bits [DLY_W+OUT_W-1:DLY_W], and the stop flag in the most significant bit.
- R4: An entry whose delay count is N drives its output vector for exactly N+1 clock cycles, so a count of zero gives one cycle. The following entry starts on the very next cycle.
- R5: Every accepted trigger starts playback at address 0, and entries are played in ascending address order.
- R6: Once the flagged entry's last cycle has passed, `wave_out` returns to the idle value and `busy` goes low on the same edge.
- R7: While `busy` is high, or while it is in the acceptance cycle, rising edges on `trig_in` are ignored. A trigger that stays high does not start a second run.
- R8: A write made while the block is idle is used by the next run.
- R9: A write made during a run, from the acceptance cycle onward, has no effect on that run's waveform. It is used by the next run, and when the same address is written more than once, the last value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous start trigger |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DLY_W+OUT_W+1 | Entry to store: {stop, outputs, delay} |
| wave_out | output | OUT_W | Waveform output lines |
| busy | output | 1 | High from acceptance of a trigger until the last entry completes |

## Verification
The bench builds the block with ADDR_W=4, DLY_W=10 and OUT_W=4. This puts a 16-entry program within reach, which lets the bench step through every one of the 16 output codes, run a list that fills every address, and hold an entry for the maximum count of 1023. Expected waveforms come arithmetically from the bench's own image of the programmed entries. The bench checks them cycle by cycle against the fixed trigger-to-output latency. It also covers writes issued mid-run, including repeated writes to one address, retriggers during a run, and a trigger held high past the end of a run.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/wseq_sync.sv
module wseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/wseq_bank_track.sv
module wseq_bank_track #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              accept,
    input  logic              running,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              wr_bank,
    output logic              rd_bank
);
    typedef struct packed {
        logic [DEPTH-1:0] newest;
        logic [DEPTH-1:0] snap;
    } track_t;

    track_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (running) wr_bank = ~t_q.snap[wr_addr];
        else         wr_bank = ~t_q.newest[wr_addr];
        if (wr_en) t_d.newest[wr_addr] = wr_bank;
        if (accept) t_d.snap = t_q.newest;
        if (accept) rd_bank = t_q.newest[rd_addr];
        else        rd_bank = t_q.snap[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/wseq_bank_mem.sv
module wseq_bank_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 21,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int BANKS = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_bank,
    output logic [DATA_W-1:0] rd_data
);
    logic rd_sel_q;

    for (genvar b = 0; b < BANKS; b++) begin : bank_g
        logic [DATA_W-1:0] ram [DEPTH];
        logic [DATA_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) ram[wr_addr] <= wr_data;
            rd_q <= ram[rd_addr];
        end
    end

    always_ff @(posedge clk) rd_sel_q <= rd_bank;

    assign rd_data = rd_sel_q ? bank_g[1].rd_q : bank_g[0].rd_q;

endmodule

// File: rtl/wseq_engine.sv
module wseq_engine
    import wseq_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter int              DLY_W    = 16,
    parameter int              OUT_W    = 4,
    parameter logic [OUT_W-1:0] IDLE_OUT = '0,
    localparam int             ENTRY_W  = DLY_W + OUT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_rise,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               accept,
    output logic               running,
    output logic [OUT_W-1:0]   wave_out,
    output logic               busy,
    output logic [DLY_W-1:0]   cnt_o,
    output logic               load_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] idx;
        logic [DLY_W-1:0]  cnt;
        logic              last;
        logic [OUT_W-1:0]  out;
    } eng_t;

    eng_t e_d, e_q;

    logic [DLY_W-1:0] ent_dly;
    logic [OUT_W-1:0] ent_out;
    logic             ent_last;

    assign ent_dly  = entry[DLY_W-1:0];
    assign ent_out  = entry[DLY_W+OUT_W-1:DLY_W];
    assign ent_last = entry[ENTRY_W-1];

    assign accept  = (e_q.st == ST_IDLE) && trig_rise;
    assign running = (e_q.st != ST_IDLE);

    always_comb begin
        e_d = e_q;
        unique case (e_q.st)
            ST_IDLE: begin
                if (trig_rise) begin
                    e_d.st  = ST_LOAD;
                    e_d.idx = '0;
                end
            end
            ST_LOAD: begin
                e_d.out  = ent_out;
                e_d.cnt  = ent_dly;
                e_d.last = ent_last;
                e_d.idx  = e_q.idx + 1'b1;
                e_d.st   = ST_RUN;
            end
            ST_RUN: begin
                if (e_q.cnt != '0) begin
                    e_d.cnt = e_q.cnt - 1'b1;
                end else if (e_q.last) begin
                    e_d.st   = ST_IDLE;
                    e_d.out  = IDLE_OUT;
                    e_d.last = 1'b0;
                end else begin
                    e_d.out  = ent_out;
                    e_d.cnt  = ent_dly;
                    e_d.last = ent_last;
                    e_d.idx  = e_q.idx + 1'b1;
                end
            end
            default: begin
                e_d.st  = ST_IDLE;
                e_d.out = IDLE_OUT;
            end
        endcase
        rd_addr = e_d.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q     <= '0;
            e_q.st  <= ST_IDLE;
            e_q.out <= IDLE_OUT;
        end else begin
            e_q <= e_d;
        end
    end

    assign wave_out = e_q.out;
    assign busy     = running;
    assign cnt_o    = e_q.cnt;
    assign load_o   = (e_q.st == ST_LOAD);

endmodule

// File: rtl/wave_seq_top.sv
module wave_seq_top #(
    parameter int               ADDR_W      = 6,
    parameter int               DLY_W       = 16,
    parameter int               OUT_W       = 4,
    parameter int               SYNC_STAGES = 2,
    parameter logic [OUT_W-1:0] IDLE_OUT    = '0,
    localparam int              ENTRY_W     = DLY_W + OUT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [OUT_W-1:0]   wave_out,
    output logic               busy
);
    logic               trig_rise;
    logic [ADDR_W-1:0]  rd_addr;
    logic               accept;
    logic               running;
    logic               wr_bank;
    logic               rd_bank;
    logic [ENTRY_W-1:0] rd_data;
    logic [DLY_W-1:0]   eng_cnt;
    logic               eng_load;

    wseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    wseq_engine #(
        .ADDR_W   (ADDR_W),
        .DLY_W    (DLY_W),
        .OUT_W    (OUT_W),
        .IDLE_OUT (IDLE_OUT)
    ) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_rise (trig_rise),
        .entry     (rd_data),
        .rd_addr   (rd_addr),
        .accept    (accept),
        .running   (running),
        .wave_out  (wave_out),
        .busy      (busy),
        .cnt_o     (eng_cnt),
        .load_o    (eng_load)
    );

    wseq_bank_track #(.ADDR_W(ADDR_W)) track_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .accept  (accept),
        .running (running),
        .rd_addr (rd_addr),
        .wr_bank (wr_bank),
        .rd_bank (rd_bank)
    );

    wseq_bank_mem #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) mem_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_bank (rd_bank),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/wave_seq_top_checker.sv
module wave_seq_top_checker #(
    parameter int               DLY_W       = 16,
    parameter int               OUT_W       = 4,
    parameter int               SYNC_STAGES = 2,
    parameter logic [OUT_W-1:0] IDLE_OUT    = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_in,
    input logic [OUT_W-1:0] wave_out,
    input logic             busy,
    input logic [DLY_W-1:0] cnt,
    input logic             load
);
    // R1 and R6: with no run in progress the lines sit at the idle value
    p_idle_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wave_out == IDLE_OUT));

    // R2: a run only begins after the trigger has crossed the synchronizer
    p_start_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_in, SYNC_STAGES));

    // R4: while the hold count is nonzero the outputs do not move
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && cnt != '0) |=> $stable(wave_out));

    // R7: the first-entry load step is only ever entered from idle
    p_load_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !$past(busy));

    // R4: the hold count only steps down by one while the entry is held
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

bind wave_seq_top wave_seq_top_checker #(
    .DLY_W       (DLY_W),
    .OUT_W       (OUT_W),
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_OUT    (IDLE_OUT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .wave_out (wave_out),
    .busy     (busy),
    .cnt      (eng_cnt),
    .load     (eng_load)
);

// File: tb/wave_seq_top_tb_top.sv
module wave_seq_top_tb_top;
    localparam int ADDR_W  = 4;
    localparam int DLY_W   = 10;
    localparam int OUT_W   = 4;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int ENTRY_W = DLY_W + OUT_W + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trig_in = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [ENTRY_W-1:0] wr_data = '0;
    logic [OUT_W-1:0]   wave_out;
    logic               busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [OUT_W-1:0] img_out  [DEPTH];
    logic [DLY_W-1:0] img_dly  [DEPTH];
    logic             img_last [DEPTH];
    logic [OUT_W-1:0] ply_out  [DEPTH];
    logic [DLY_W-1:0] ply_dly  [DEPTH];
    logic             ply_last [DEPTH];

    always #5 clk = ~clk;

    wave_seq_top #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .OUT_W(OUT_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wave_out (wave_out),
        .busy     (busy)
    );

    task automatic check(input string tag, input logic [OUT_W:0] act, input logic [OUT_W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {busy,out} actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R3: entry layout {stop, outputs, delay}
    task automatic host_write(input int a, input logic last, input logic [OUT_W-1:0] o,
                              input logic [DLY_W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = {last, o, d};
        img_out[a] = o; img_dly[a] = d; img_last[a] = last;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drives a trigger and checks the whole run cycle by cycle.
    task automatic run_check(input string tag, input bit hold_trig);
        int k;
        for (int i = 0; i < DEPTH; i++) begin
            ply_out[i] = img_out[i]; ply_dly[i] = img_dly[i]; ply_last[i] = img_last[i];
        end
        @(negedge clk);
        trig_in = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check({"R2 pre-accept ", tag}, {busy, wave_out}, {1'b0, {OUT_W{1'b0}}});
        end
        @(negedge clk);
        check({"R2 busy rise ", tag}, {busy, wave_out}, {1'b1, {OUT_W{1'b0}}});
        if (!hold_trig) trig_in = 1'b0;
        k = 0;
        forever begin
            for (int j = 0; j <= int'(ply_dly[k]); j++) begin
                @(negedge clk);
                check({"R4 R5 hold ", tag}, {busy, wave_out}, {1'b1, ply_out[k]});
            end
            if (ply_last[k]) break;
            k = (k + 1) % DEPTH;
        end
        @(negedge clk);
        check({"R6 end ", tag}, {busy, wave_out}, {1'b0, {OUT_W{1'b0}}});
        if (hold_trig) begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                check({"R7 held trigger ", tag}, {busy, wave_out}, {1'b0, {OUT_W{1'b0}}});
            end
            trig_in = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            img_out[i] = '0; img_dly[i] = '0; img_last[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 in reset", {busy, wave_out}, '0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1 after reset", {busy, wave_out}, '0);
        end

        // Every output code, full depth, mixed short delays
        for (int i = 0; i < DEPTH; i++)
            host_write(i, (i == DEPTH - 1), OUT_W'(i), DLY_W'(i % 4));
        run_check("R3 all codes", 1'b0);
        // R5: second trigger replays from address 0
        run_check("R5 replay", 1'b0);

        // Shortest run: one entry, delay 0
        host_write(0, 1'b1, 4'hA, '0);
        run_check("R6 single", 1'b0);

        // Maximum delay count
        host_write(0, 1'b0, 4'h5, DLY_W'(1023));
        host_write(1, 1'b1, 4'hF, '0);
        run_check("R4 max delay", 1'b0);

        // R8: idle write changes the next run
        host_write(1, 1'b0, 4'h3, DLY_W'(2));
        host_write(2, 1'b1, 4'hC, DLY_W'(1));
        run_check("R8 idle write", 1'b0);

        // R9: writes during a run
        for (int i = 0; i < 4; i++)
            host_write(i, (i == 3), OUT_W'(i + 1), DLY_W'(20));
        fork
            run_check("R9 current run", 1'b0);
            begin
                repeat (30) @(negedge clk);
                host_write(0, 1'b0, 4'h9, DLY_W'(3));
                host_write(2, 1'b0, 4'h6, DLY_W'(5));
                host_write(2, 1'b0, 4'h7, DLY_W'(4));
                host_write(3, 1'b1, 4'hE, DLY_W'(0));
            end
        join
        run_check("R9 next run", 1'b0);

        // R7: retrigger during a run is ignored
        for (int i = 0; i < 3; i++)
            host_write(i, (i == 2), OUT_W'(8 + i), DLY_W'(15));
        fork
            run_check("R7 retrigger", 1'b0);
            begin
                repeat (12) @(negedge clk);
                trig_in = 1'b1;
                repeat (4) @(negedge clk);
                trig_in = 1'b0;
            end
        join
        // R7: trigger held high through the end does not restart
        run_check("R7 hold", 1'b1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule